// File: doc/BRIEF.md
# Control Block CRC16 Checker

This unit checks the two 16-bit integrity codes of a fixed-layout, big-endian command block while the block streams through it, one byte per accepted beat. One code protects a header region plus the used part of the input-parameter area. The other protects the used part of the result area. Software programs a start offset and a used length for each region. The unit counts bytes from the start of the block and feeds each CRC engine only the bytes that fall inside that engine's window. It also picks the two expected codes out of the same stream.

When the final byte of a block is accepted, the unit registers both computed codes and a match flag for each region, and pulses `done` for one cycle. The results stay on the outputs until the next block ends. `res_valid` marks them as belonging to the most recent block, and it drops as soon as the first byte of a new block is taken.

The input side is a valid/ready stream. `in_ready` is always high, so the producer controls the pace: it stalls simply by holding `in_valid` low, and the unit ignores data and `in_last` on those cycles. The four configuration inputs must stay stable from the first byte of a block through its last byte.

Top module: `ctl_blk_crc_chk`

## Requirements
- R1: Both codes use generator polynomial 0x1021, are seeded with 0xFFFF at the start of every block, take each byte most significant bit first, and get no final XOR. For example, the ASCII bytes "123456789" give 0x29B1.
- R2: The input engine takes the bytes at block offsets from `cfg_in_start` up to, but not including, `cfg_in_start + cfg_in_len + 24`. The 24 is a fixed header extension.
- R3: The output engine takes the bytes at offsets from `cfg_out_start` up to, but not including, `cfg_out_start + cfg_out_len`. No header is added.
- R4: The expected input code is the big-endian pair at offsets 0 and 1, high byte first. The expected output code is the big-endian pair at offsets 194 and 195.
- R5: `done` is high for exactly the one cycle after the beat that carries `in_valid` and `in_last`. In that cycle `crc_in` and `crc_out` show the computed codes and `res_valid` is high.
- R6: `crc_ok_in` and `crc_ok_out` are 1 exactly when the matching computed code equals the matching expected code.
- R7: With `cfg_out_len` = 0, `crc_out` is 0xFFFF and is still compared against the expected output code. With `cfg_in_len` = 0, the input window still spans 24 bytes.
- R8: The results hold their values until the next block ends. `res_valid` goes low in the cycle after the first byte of the next block is accepted.
- R9: `in_ready` is always 1. A cycle with `in_valid` low changes no state, whatever values `in_data` and `in_last` carry.
- R10: If a block ends before a window or an expected field is complete, the engine uses only the bytes that arrived, and each missing expected byte counts as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Always 1; the unit never back-pressures |
| in_data | input | 8 | Block byte, in block order |
| in_last | input | 1 | Marks the final byte of the block |
| cfg_in_start | input | OFS_W | First offset of the input window |
| cfg_in_len | input | OFS_W | Used input-parameter byte count |
| cfg_out_start | input | OFS_W | First offset of the output window |
| cfg_out_len | input | OFS_W | Used result-area byte count |
| done | output | 1 | One-cycle pulse after the final byte |
| res_valid | output | 1 | Results belong to the last finished block |
| crc_in | output | 16 | Computed input-region code |
| crc_out | output | 16 | Computed output-region code |
| crc_ok_in | output | 1 | Input code matches its expected value |
| crc_ok_out | output | 1 | Output code matches its expected value |

## Verification
Three things can fall on the same beat: the end of the block, the last byte of a window, and the low byte of the expected field. When they coincide, the result and the compare must use the CRC updated by that byte and the expected value completed by that byte, not the values from the previous cycle. A directed block ends at offset 195 with the output window stretched to end at the same byte. Its reported code and match flag are judged against a bench model of the whole delivered block. Random blocks with idle gaps, plus truncated blocks and blocks with zero length, cover the other alignments.

// File: rtl/ctl_blk_crc_pkg.sv
package ctl_blk_crc_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // One byte, MSB first, no reflection
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/blk_byte_counter.sv
module blk_byte_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             blk_end,
  output logic [CNT_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)             idx <= '0;
    else if (blk_end)       idx <= '0;
    else if (beat && idx != '1) idx <= idx + 1'b1;
  end

  // R5
  idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> idx == '0);
endmodule

// File: rtl/crc_region.sv
module crc_region
  import ctl_blk_crc_pkg::*;
#(
  parameter int OFS_W     = 8,
  parameter int CNT_W     = 9,
  parameter int HDR_BYTES = 0,
  parameter int EXP_OFS   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             blk_end,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       byte_in,
  input  logic [OFS_W-1:0] win_start,
  input  logic [OFS_W-1:0] win_len,
  output logic [15:0]      res_crc,
  output logic             res_ok
);
  localparam int EW = CNT_W + 1;
  localparam logic [CNT_W-1:0] EXP_HI = CNT_W'(EXP_OFS);
  localparam logic [CNT_W-1:0] EXP_LO = CNT_W'(EXP_OFS + 1);

  logic [15:0]   crc_q, crc_nxt, exp_q, exp_nxt;
  logic [EW-1:0] win_end, pos;
  logic          take;

  assign win_end = EW'(win_start) + EW'(win_len) + EW'(HDR_BYTES);
  assign pos     = EW'(idx);
  assign take    = beat && (pos >= EW'(win_start)) && (pos < win_end);
  assign crc_nxt = take ? crc16_step(crc_q, byte_in) : crc_q;

  always_comb begin
    exp_nxt = exp_q;
    if (beat && idx == EXP_HI) exp_nxt[15:8] = byte_in;
    if (beat && idx == EXP_LO) exp_nxt[7:0]  = byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= CRC_SEED;
      exp_q   <= '0;
      res_crc <= CRC_SEED;
      res_ok  <= 1'b0;
    end else if (blk_end) begin
      crc_q   <= CRC_SEED;
      exp_q   <= '0;
      res_crc <= crc_nxt;
      res_ok  <= (crc_nxt == exp_nxt);
    end else begin
      crc_q <= crc_nxt;
      exp_q <= exp_nxt;
    end
  end

  // R1
  reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> crc_q == CRC_SEED);
  // R2
  outside_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !blk_end) |=> $stable(crc_q));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_end |=> ($stable(res_crc) && $stable(res_ok)));
  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> ($stable(crc_q) && $stable(exp_q)));
endmodule

// File: rtl/ctl_blk_crc_chk.sv
module ctl_blk_crc_chk #(
  parameter int OFS_W       = 8,
  parameter int HDR_BYTES   = 24,
  parameter int EXP_IN_OFS  = 0,
  parameter int EXP_OUT_OFS = 194
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [OFS_W-1:0] cfg_in_start,
  input  logic [OFS_W-1:0] cfg_in_len,
  input  logic [OFS_W-1:0] cfg_out_start,
  input  logic [OFS_W-1:0] cfg_out_len,
  output logic             done,
  output logic             res_valid,
  output logic [15:0]      crc_in,
  output logic [15:0]      crc_out,
  output logic             crc_ok_in,
  output logic             crc_ok_out
);
  localparam int CNT_W = OFS_W + 1;
  localparam int NREG  = 2;

  logic             beat, blk_end;
  logic [CNT_W-1:0] idx;
  logic [OFS_W-1:0] st  [NREG];
  logic [OFS_W-1:0] ln  [NREG];
  logic [15:0]      crc [NREG];
  logic             ok  [NREG];

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;
  assign blk_end  = beat && in_last;

  assign st[0] = cfg_in_start;  assign ln[0] = cfg_in_len;
  assign st[1] = cfg_out_start; assign ln[1] = cfg_out_len;

  blk_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .beat(beat), .blk_end(blk_end), .idx(idx));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    crc_region #(
      .OFS_W(OFS_W), .CNT_W(CNT_W),
      .HDR_BYTES(g == 0 ? HDR_BYTES : 0),
      .EXP_OFS(g == 0 ? EXP_IN_OFS : EXP_OUT_OFS)
    ) u_region (
      .clk(clk), .rst_n(rst_n), .beat(beat), .blk_end(blk_end), .idx(idx),
      .byte_in(in_data), .win_start(st[g]), .win_len(ln[g]),
      .res_crc(crc[g]), .res_ok(ok[g]));
  end

  assign crc_in     = crc[0];
  assign crc_out    = crc[1];
  assign crc_ok_in  = ok[0];
  assign crc_ok_out = ok[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      done <= blk_end;
      if (blk_end)   res_valid <= 1'b1;
      else if (beat) res_valid <= 1'b0;
    end
  end

  // R5
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> (done && res_valid));
  // R5
  done_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_end |=> !done);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !in_last) |=> !res_valid);
endmodule

// File: tb/test_ctl_blk_crc_chk.sv
module test_ctl_blk_crc_chk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [7:0] cfg_in_start = 8'd8, cfg_in_len = 8'd0, cfg_out_start = 8'd128, cfg_out_len = 8'd0;
  logic in_ready, done, res_valid, crc_ok_in, crc_ok_out;
  logic [15:0] crc_in, crc_out;

  int checks = 0, fails = 0;
  logic [7:0] blk [0:255];

  always #5 clk = ~clk;

  ctl_blk_crc_chk i_ctl_blk_crc_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last),
    .cfg_in_start(cfg_in_start), .cfg_in_len(cfg_in_len),
    .cfg_out_start(cfg_out_start), .cfg_out_len(cfg_out_len),
    .done(done), .res_valid(res_valid), .crc_in(crc_in), .crc_out(crc_out),
    .crc_ok_in(crc_ok_in), .crc_ok_out(crc_ok_out));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_crc(input int s, input int l, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = s; i < s + l && i < n; i++)
      for (int b = 7; b >= 0; b--)
        c = (c[15] ^ blk[i][b]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c;
  endfunction

  function automatic logic [15:0] model_exp(input int e, input int n);
    logic [7:0] hi = (n > e) ? blk[e] : 8'h00;
    logic [7:0] lo = (n > e + 1) ? blk[e + 1] : 8'h00;
    return {hi, lo};
  endfunction

  // Streams blk[0..n-1] with optional idle gaps and checks the results
  task automatic run_block(input int n, input bit gaps, input string tag);
    logic [15:0] ei, eo, ci, co, hold_i;
    ci = model_crc(cfg_in_start, cfg_in_len + 24, n);
    co = model_crc(cfg_out_start, cfg_out_len, n);
    ei = model_exp(0, n);
    eo = model_exp(194, n);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        for (int g = 0; g < 1 + int'($urandom % 2); g++) begin
          in_valid = 1'b0; in_data = 8'($urandom); in_last = 1'($urandom);
          @(negedge clk);
        end
      end
      in_valid = 1'b1; in_data = blk[i]; in_last = (i == n - 1);
      @(negedge clk);
      if (i == 0 && n > 1) chk(res_valid == 1'b0, {"R8 valid drop ", tag}, res_valid, 0);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(done == 1'b1 && res_valid == 1'b1, {"R5 done ", tag}, {done, res_valid}, 3);
    chk(crc_in == ci, {"R2 crc_in ", tag}, crc_in, ci);
    chk(crc_out == co, {"R3 crc_out ", tag}, crc_out, co);
    chk(crc_ok_in == (ci == ei), {"R6 ok_in ", tag}, crc_ok_in, ci == ei);
    chk(crc_ok_out == (co == eo), {"R6 ok_out ", tag}, crc_ok_out, co == eo);
    hold_i = crc_in;
    in_data = 8'hA5; in_last = 1'b1;          // ignored, valid low (R9)
    @(negedge clk); @(negedge clk);
    in_last = 1'b0;
    chk(done == 1'b0, {"R5 single pulse ", tag}, done, 0);
    chk(crc_in == hold_i && res_valid, {"R8/R9 hold ", tag}, crc_in, hold_i);
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++) blk[i] = 8'($urandom);
  endtask

  // Place correct codes into the expected fields (windows kept clear of them)
  task automatic seal(input int n, input bit bad_in, input bit bad_out);
    logic [15:0] c;
    c = model_crc(cfg_in_start, cfg_in_len + 24, n) ^ (bad_in ? 16'h0100 : 16'h0);
    blk[0] = c[15:8]; blk[1] = c[7:0];
    c = model_crc(cfg_out_start, cfg_out_len, n) ^ (bad_out ? 16'h0001 : 16'h0);
    blk[194] = c[15:8]; blk[195] = c[7:0];
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(done == 0 && res_valid == 0 && in_ready == 1, "R5/R9 reset flags", {done, res_valid, in_ready}, 1);
    chk(crc_in == 16'hFFFF && crc_out == 16'hFFFF, "R1 reset crc", crc_in, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 known vector in output window, R4 expected out matches it
    fill_random(196);
    cfg_in_start = 8'd8; cfg_in_len = 8'd16; cfg_out_start = 8'd128; cfg_out_len = 8'd9;
    for (int i = 0; i < 9; i++) blk[128 + i] = 8'h31 + 8'(i);
    seal(196, 1'b0, 1'b0);
    run_block(196, 1'b0, "vector");
    chk(crc_out == 16'h29B1, "R1 check value", crc_out, 16'h29B1);
    chk(crc_ok_in && crc_ok_out, "R4 sealed ok", {crc_ok_in, crc_ok_out}, 3);

    // R7 zero lengths
    fill_random(196);
    cfg_in_len = 8'd0; cfg_out_len = 8'd0;
    seal(196, 1'b0, 1'b0);
    run_block(196, 1'b1, "zero len");
    chk(crc_out == 16'hFFFF && crc_ok_out, "R7 out seed compared", crc_out, 16'hFFFF);

    // Same cycle: last byte ends window and completes expected field
    fill_random(196);
    cfg_in_len = 8'd40; cfg_out_start = 8'd130; cfg_out_len = 8'd66;
    run_block(196, 1'b1, "same cycle");

    // R10 truncated block: output window and expected field missing
    fill_random(100);
    cfg_in_len = 8'd96; cfg_out_start = 8'd128; cfg_out_len = 8'd64;
    run_block(100, 1'b0, "short");
    chk(crc_out == 16'hFFFF && !crc_ok_out, "R10 truncated out", crc_out, 16'hFFFF);

    // Random blocks
    for (int k = 0; k < 30; k++) begin
      fill_random(196);
      cfg_in_start = 8'd8 + 8'($urandom % 8);
      cfg_in_len   = 8'($urandom % 97);
      cfg_out_start = 8'd128;
      cfg_out_len  = 8'($urandom % 65);
      seal(196, 1'($urandom), 1'($urandom));
      run_block(196, 1'b1, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule